// File: doc/BRIEF.md
# TCM Read Error Event Generator

This block turns the per-read check results of the tightly coupled memory ports into single-cycle event pulses. Each erroneous read is reported in two ways. The first is a memory-side report, one fatal and one correctable pulse per port. It appears a fixed three cycles after the read and does not depend on whether the data was ever used. The second is a requester-side report, one fatal and one correctable pulse for each consumer of memory data: instruction fetch, load/store and the DMA slave path. It is raised only when the data was actually consumed.

A read that is not speculative produces its requester-side pulse in the same cycle as its memory-side pulse. A speculative read parks its error in a small table for its port, indexed by a tag. A later resolve pulse either commits the entry, which raises the requester-side event in the next cycle, or cancels it, which drops the entry silently. Reads that are part of a read-modify-write for a partial store are presented on the same inputs as any other read. The external error response of an access is an input that is accepted but plays no part in any event.

Top module: `tcm_err_events`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every event output is low.
- R2: A read with `rd_dbe` set raises `mem_fatal[p]` for its port exactly three cycles after the read cycle, and does not raise `mem_corr[p]`, even if `rd_sbe` is also set.
- R3: A read with `rd_sbe` set and `rd_dbe` clear raises `mem_corr[p]` exactly three cycles after the read cycle.
- R4: Memory-side events are raised for speculative reads as well, including reads whose speculation is later cancelled.
- R5: `rd_ext` changes neither the memory-side nor the requester-side events of a read.
- R6: Error flags presented while `rd_vld[p]` is low raise no event of any kind.
- R7: A non-speculative erroneous read with requester code 0 (fetch), 1 (load/store) or 2 (DMA) raises bit `code` of `req_fatal` or `req_corr` in the same cycle as its memory-side event.
- R8: A speculative erroneous read raises no requester-side event until a commit (`rsv_vld`=1, `rsv_commit`=1) arrives with the same port and tag, at least one cycle after the read. The event is then raised in the cycle after the commit.
- R9: A cancel (`rsv_vld`=1, `rsv_commit`=0) with matching port and tag discards the pending error, and a later commit to that tag raises nothing.
- R10: Requester code 3 means no requester: such reads raise memory-side events only.
- R11: A newer speculative read to the same port and tag replaces the pending entry. A clean one leaves nothing to release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_vld | input | NUM_PORTS | Read data cycle strobe, one bit per port |
| rd_req | input | 2*NUM_PORTS | Requester code per port: 0 fetch, 1 load/store, 2 DMA, 3 none |
| rd_spec | input | NUM_PORTS | Read is speculative |
| rd_tag | input | TAG_W*NUM_PORTS | Speculation tag per port |
| rd_sbe | input | NUM_PORTS | Single-bit (correctable) error detected |
| rd_dbe | input | NUM_PORTS | Double-bit or parity (fatal) error detected |
| rd_ext | input | NUM_PORTS | External error response on the access |
| rsv_vld | input | 1 | Resolve pulse for a speculative read |
| rsv_commit | input | 1 | 1 = commit, 0 = cancel |
| rsv_port | input | PORT_W | Port of the resolved read |
| rsv_tag | input | TAG_W | Tag of the resolved read |
| mem_fatal | output | NUM_PORTS | Memory-side fatal event per port |
| mem_corr | output | NUM_PORTS | Memory-side correctable event per port |
| req_fatal | output | 3 | Requester-side fatal event: bit 0 fetch, 1 load/store, 2 DMA |
| req_corr | output | 3 | Requester-side correctable event, same bit order |

## Verification
The bench aims at the places where the two reporting paths part ways. A read with both error flags set must come out as fatal only; a design that decoded it loosely would pulse both outputs. A cancelled or overwritten speculative entry followed by a commit must stay silent, where a table that did not clear entries would report stale errors. An unowned requester code and the external error flag are driven against reads that carry errors, to catch a design that lets either one mask or create events. Randomized traffic mixes commits and reads that land on the same tag in the same cycle, so an off-by-one in the three-cycle delay or the wrong write-versus-clear priority shows up as a missing or extra pulse.

// File: rtl/tcm_evt_pkg.sv
// Shared definitions for the TCM read error event generator.
// Assumes exactly three requesters; code 3 marks a read with no owner.
package tcm_evt_pkg;
    localparam int EVT_LAT = 3;   // memory-side event delay in cycles
    localparam int REQ_W   = 2;
    localparam int NUM_REQ = 3;

    typedef enum logic [REQ_W-1:0] {
        REQ_FETCH = 2'd0,
        REQ_LDST  = 2'd1,
        REQ_DMA   = 2'd2,
        REQ_NONE  = 2'd3
    } req_e;

    typedef struct packed {
        logic fatal;
        logic corr;
        logic spec;
        req_e req;
    } evt_t;
endpackage

// File: rtl/tcm_evt_pipe.sv
// Per-port delay line. Classifies a read's check result (fatal wins over
// correctable) and carries it with its requester and speculation flag
// through EVT_LAT registers, so the output lines up with the read.
// Assumes the check flags are valid in the same cycle as rd_vld.
module tcm_evt_pipe
    import tcm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_vld,
    input  logic             rd_sbe,
    input  logic             rd_dbe,
    input  logic             rd_spec,
    input  logic [REQ_W-1:0] rd_req,
    output evt_t             evt_o
);
    evt_t stg_in;
    evt_t stg [EVT_LAT];

    // Classify the incoming read; a double-bit flag suppresses correctable.
    always_comb begin
        stg_in.fatal = rd_vld && rd_dbe;
        stg_in.corr  = rd_vld && rd_sbe && !rd_dbe;
        stg_in.spec  = rd_spec;
        stg_in.req   = req_e'(rd_req);
    end

    // Shift the classified result down the delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < EVT_LAT; i++) stg[i] <= '0;
        end else begin
            stg[0] <= stg_in;
            for (int i = 1; i < EVT_LAT; i++) stg[i] <= stg[i-1];
        end
    end

    assign evt_o = stg[EVT_LAT-1];

    AST_MEM_FATAL_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o.fatal |-> $past(rd_vld && rd_dbe, 3)); // R2
    AST_MEM_CORR_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o.corr |-> $past(rd_vld && rd_sbe && !rd_dbe, 3)); // R3
endmodule

// File: rtl/tcm_evt_spec_tbl.sv
// Per-port table of pending speculative read errors, indexed by tag.
// A speculative read writes its entry (clean reads clear it); a resolve
// for this port frees it and, on commit, raises a release pulse next cycle.
// Assumes a resolve arrives at least one cycle after its read.
module tcm_evt_spec_tbl
    import tcm_evt_pkg::*;
#(
    parameter int TAG_W    = 3,
    parameter int PORT_W   = 1,
    parameter int PORT_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_vld,
    input  logic              rd_spec,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic              rd_sbe,
    input  logic              rd_dbe,
    input  logic [REQ_W-1:0]  rd_req,
    input  logic              rsv_vld,
    input  logic              rsv_commit,
    input  logic [PORT_W-1:0] rsv_port,
    input  logic [TAG_W-1:0]  rsv_tag,
    output logic              rel_fatal,
    output logic              rel_corr,
    output req_e              rel_req
);
    localparam int DEPTH = 1 << TAG_W;

    logic [DEPTH-1:0] pend_v;
    logic [DEPTH-1:0] pend_f;
    req_e             pend_r [DEPTH];
    logic             port_hit;
    logic             spec_wr;

    assign port_hit = rsv_vld && (rsv_port == PORT_W'(PORT_IDX));
    assign spec_wr  = rd_vld && rd_spec;

    // Register the release of a committed entry that holds an error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_fatal <= 1'b0;
            rel_corr  <= 1'b0;
            rel_req   <= REQ_NONE;
        end else begin
            rel_fatal <= port_hit && rsv_commit && pend_v[rsv_tag] && pend_f[rsv_tag];
            rel_corr  <= port_hit && rsv_commit && pend_v[rsv_tag] && !pend_f[rsv_tag];
            rel_req   <= pend_r[rsv_tag];
        end
    end

    // Update entries: a new speculative read wins over a resolve of the same tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= '0;
            pend_f <= '0;
            for (int i = 0; i < DEPTH; i++) pend_r[i] <= REQ_NONE;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (spec_wr && (rd_tag == TAG_W'(i))) begin
                    pend_v[i] <= rd_sbe || rd_dbe;
                    pend_f[i] <= rd_dbe;
                    pend_r[i] <= req_e'(rd_req);
                end else if (port_hit && (rsv_tag == TAG_W'(i))) begin
                    pend_v[i] <= 1'b0;
                end
            end
        end
    end

    AST_REL_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_fatal || rel_corr) |-> $past(port_hit && rsv_commit)); // R8
    AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (port_hit && !rsv_commit && !(spec_wr && rd_tag == rsv_tag))
        |=> !pend_v[$past(rsv_tag)]); // R9
endmodule

// File: rtl/tcm_err_events.sv
// Top of the TCM read error event generator. Per port, a delay line
// produces memory-side events three cycles after each read, and a tag
// table holds speculative errors until commit. Requester-side events are
// the OR of non-speculative pipe outputs and committed releases, split by
// requester code. The external error flag is accepted and has no effect.
module tcm_err_events
    import tcm_evt_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int TAG_W     = 3,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS-1:0]       rd_vld,
    input  logic [NUM_PORTS*REQ_W-1:0] rd_req,
    input  logic [NUM_PORTS-1:0]       rd_spec,
    input  logic [NUM_PORTS*TAG_W-1:0] rd_tag,
    input  logic [NUM_PORTS-1:0]       rd_sbe,
    input  logic [NUM_PORTS-1:0]       rd_dbe,
    input  logic [NUM_PORTS-1:0]       rd_ext,
    input  logic                       rsv_vld,
    input  logic                       rsv_commit,
    input  logic [PORT_W-1:0]          rsv_port,
    input  logic [TAG_W-1:0]           rsv_tag,
    output logic [NUM_PORTS-1:0]       mem_fatal,
    output logic [NUM_PORTS-1:0]       mem_corr,
    output logic [NUM_REQ-1:0]         req_fatal,
    output logic [NUM_REQ-1:0]         req_corr
);
    evt_t pe        [NUM_PORTS];
    logic rel_fatal [NUM_PORTS];
    logic rel_corr  [NUM_PORTS];
    req_e rel_req   [NUM_PORTS];
    logic ext_unused;

    assign ext_unused = &{1'b0, rd_ext};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        tcm_evt_pipe u_pipe (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_vld  (rd_vld[p]),
            .rd_sbe  (rd_sbe[p]),
            .rd_dbe  (rd_dbe[p]),
            .rd_spec (rd_spec[p]),
            .rd_req  (rd_req[p*REQ_W +: REQ_W]),
            .evt_o   (pe[p])
        );

        tcm_evt_spec_tbl #(
            .TAG_W    (TAG_W),
            .PORT_W   (PORT_W),
            .PORT_IDX (p)
        ) u_tbl (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_vld     (rd_vld[p]),
            .rd_spec    (rd_spec[p]),
            .rd_tag     (rd_tag[p*TAG_W +: TAG_W]),
            .rd_sbe     (rd_sbe[p]),
            .rd_dbe     (rd_dbe[p]),
            .rd_req     (rd_req[p*REQ_W +: REQ_W]),
            .rsv_vld    (rsv_vld),
            .rsv_commit (rsv_commit),
            .rsv_port   (rsv_port),
            .rsv_tag    (rsv_tag),
            .rel_fatal  (rel_fatal[p]),
            .rel_corr   (rel_corr[p]),
            .rel_req    (rel_req[p])
        );
    end

    // Drive memory-side events and merge requester-side sources per requester.
    always_comb begin
        req_fatal = '0;
        req_corr  = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            mem_fatal[p] = pe[p].fatal;
            mem_corr[p]  = pe[p].corr;
            for (int r = 0; r < NUM_REQ; r++) begin
                if (!pe[p].spec && int'(pe[p].req) == r) begin
                    req_fatal[r] = req_fatal[r] | pe[p].fatal;
                    req_corr[r]  = req_corr[r]  | pe[p].corr;
                end
                if (int'(rel_req[p]) == r) begin
                    req_fatal[r] = req_fatal[r] | rel_fatal[p];
                    req_corr[r]  = req_corr[r]  | rel_corr[p];
                end
            end
        end
    end

    AST_REQ_FATAL_SOURCED: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_fatal) |-> ($past(|(rd_vld & rd_dbe & ~rd_spec), 3)
                          || $past(rsv_vld && rsv_commit))); // R7
    AST_REQ_CORR_SOURCED: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_corr) |-> ($past(|(rd_vld & rd_sbe & ~rd_spec), 3)
                         || $past(rsv_vld && rsv_commit))); // R8
endmodule

// File: tb/tcm_err_events_tb_top.sv
`timescale 1ns/1ps
module tcm_err_events_tb_top;
    localparam int NP = 2;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] rd_vld = '0, rd_spec = '0, rd_sbe = '0, rd_dbe = '0, rd_ext = '0;
    logic [2*NP-1:0]  rd_req = '0;
    logic [TW*NP-1:0] rd_tag = '0;
    logic          rsv_vld = 1'b0, rsv_commit = 1'b0;
    logic [0:0]    rsv_port = '0;
    logic [TW-1:0] rsv_tag = '0;
    logic [NP-1:0] mem_fatal, mem_corr;
    logic [2:0]    req_fatal, req_corr;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    // expected outputs, ring indexed by cycle
    logic [NP-1:0] e_mf [8];
    logic [NP-1:0] e_mc [8];
    logic [2:0]    e_rf [8];
    logic [2:0]    e_rc [8];
    // bench view of pending speculative errors
    bit m_v [NP][8];
    bit m_f [NP][8];
    int m_r [NP][8];

    always #10 clk = ~clk;   // 50 MHz

    tcm_err_events #(.NUM_PORTS(NP), .TAG_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_req(rd_req),
        .rd_spec(rd_spec), .rd_tag(rd_tag), .rd_sbe(rd_sbe), .rd_dbe(rd_dbe),
        .rd_ext(rd_ext), .rsv_vld(rsv_vld), .rsv_commit(rsv_commit),
        .rsv_port(rsv_port), .rsv_tag(rsv_tag), .mem_fatal(mem_fatal),
        .mem_corr(mem_corr), .req_fatal(req_fatal), .req_corr(req_corr));

    function automatic bit is_fatal(bit sbe, bit dbe);
        return dbe;
    endfunction

    function automatic bit is_corr(bit sbe, bit dbe);
        return sbe && !dbe;
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s cycle %0d actual=%b expected=%b", req, cyc, act, exp);
        end
    endtask

    task automatic clear_in();
        rd_vld = '0; rd_spec = '0; rd_sbe = '0; rd_dbe = '0; rd_ext = '0;
        rd_req = '0; rd_tag = '0; rsv_vld = 0; rsv_commit = 0; rsv_port = '0; rsv_tag = '0;
    endtask

    task automatic set_rd(int p, int rq, bit spec, int tag, bit sbe, bit dbe, bit ext);
        rd_vld[p] = 1; rd_req[p*2 +: 2] = 2'(rq); rd_spec[p] = spec;
        rd_tag[p*TW +: TW] = TW'(tag); rd_sbe[p] = sbe; rd_dbe[p] = dbe; rd_ext[p] = ext;
    endtask

    task automatic set_rsv(int p, bit commit, int tag);
        rsv_vld = 1; rsv_commit = commit; rsv_port = 1'(p); rsv_tag = TW'(tag);
    endtask

    // apply model for the current inputs (resolve first, then reads)
    task automatic model();
        int s3 = (cyc + 3) % 8;
        int s1 = (cyc + 1) % 8;
        if (rsv_vld && m_v[rsv_port][rsv_tag]) begin
            if (rsv_commit && m_r[rsv_port][rsv_tag] != 3) begin
                if (m_f[rsv_port][rsv_tag]) e_rf[s1][m_r[rsv_port][rsv_tag]] = 1;
                else                        e_rc[s1][m_r[rsv_port][rsv_tag]] = 1;
            end
            m_v[rsv_port][rsv_tag] = 0;
        end
        for (int p = 0; p < NP; p++) begin
            if (rd_vld[p]) begin
                bit f = is_fatal(rd_sbe[p], rd_dbe[p]);
                bit c = is_corr(rd_sbe[p], rd_dbe[p]);
                int rq = int'(rd_req[p*2 +: 2]);
                int tg = int'(rd_tag[p*TW +: TW]);
                e_mf[s3][p] |= f;
                e_mc[s3][p] |= c;
                if (!rd_spec[p] && rq != 3) begin
                    e_rf[s3][rq] |= f;
                    e_rc[s3][rq] |= c;
                end
                if (rd_spec[p]) begin
                    m_v[p][tg] = f || c;
                    m_f[p][tg] = f;
                    m_r[p][tg] = rq;
                end
            end
        end
    endtask

    // one clock: model, edge, then check outputs of the new cycle
    task automatic tick();
        int s;
        model();
        @(posedge clk);
        cyc++;
        @(negedge clk);
        s = cyc % 8;
        chk("R2/R4 mem_fatal", 4'(mem_fatal), 4'(e_mf[s]));
        chk("R3/R4 mem_corr", 4'(mem_corr), 4'(e_mc[s]));
        chk("R7/R8 req_fatal", 4'(req_fatal), 4'(e_rf[s]));
        chk("R7/R8 req_corr", 4'(req_corr), 4'(e_rc[s]));
        e_mf[s] = '0; e_mc[s] = '0; e_rf[s] = '0; e_rc[s] = '0;
        clear_in();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(2_000_000);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) begin
            e_mf[i] = '0; e_mc[i] = '0; e_rf[i] = '0; e_rc[i] = '0;
        end
        for (int p = 0; p < NP; p++)
            for (int t = 0; t < 8; t++) begin m_v[p][t] = 0; m_f[p][t] = 0; m_r[p][t] = 3; end
        // R1: outputs quiet during reset, even with error traffic on the inputs
        repeat (3) @(negedge clk);
        set_rd(0, 0, 0, 0, 1, 1, 0);
        @(negedge clk);
        chk("R1 reset", {mem_fatal, mem_corr}, 4'b0);
        chk("R1 reset", {1'b0, req_fatal}, 4'b0);
        clear_in();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R2: both flags -> fatal only, fetch requester
        set_rd(0, 0, 0, 0, 1, 1, 0); idle(4);
        // R3: correctable on port 1, load/store
        set_rd(1, 1, 0, 0, 1, 0, 0); idle(4);
        // R6: flags without a read strobe
        rd_sbe = 2'b11; rd_dbe = 2'b01; idle(4);
        // R5: external error with a correctable read, and with a clean read
        set_rd(0, 2, 0, 0, 1, 0, 1); set_rd(1, 0, 0, 0, 0, 0, 1); idle(4);
        // R8 and R4: speculative fatal DMA read, commit later
        set_rd(0, 2, 1, 5, 0, 1, 0); idle(6);
        set_rsv(0, 1, 5); idle(3);
        // R9: speculative correctable read cancelled, then committed
        set_rd(1, 1, 1, 2, 1, 0, 0); tick();
        set_rsv(1, 0, 2); tick();
        set_rsv(1, 1, 2); idle(4);
        // R10: no-owner requester code
        set_rd(0, 3, 0, 0, 0, 1, 0); set_rd(1, 3, 0, 0, 1, 0, 0); idle(4);
        // R11: erroneous speculative entry replaced by a clean read, then commit
        set_rd(0, 0, 1, 1, 0, 1, 0); tick();
        set_rd(0, 0, 1, 1, 0, 0, 0); tick();
        set_rsv(0, 1, 1); idle(4);
        // R8: commit on wrong port leaves entry for the right one
        set_rd(1, 0, 1, 6, 1, 0, 0); tick();
        set_rsv(0, 1, 6); tick();
        set_rsv(1, 1, 6); idle(4);

        // constrained random traffic
        for (int n = 0; n < 2000; n++) begin
            for (int p = 0; p < NP; p++) begin
                if ($urandom % 2 == 0)
                    set_rd(p, int'($urandom % 4), 1'($urandom % 2), int'($urandom % 8),
                           1'($urandom % 4 == 0), 1'($urandom % 4 == 0), 1'($urandom % 2));
            end
            if ($urandom % 3 == 0)
                set_rsv(int'($urandom % 2), 1'($urandom % 2), int'($urandom % 8));
            tick();
        end
        idle(5);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule